// File: doc/BRIEF.md
# Reaction Timer with Two-Digit Decimal Readout

This block measures how quickly a person responds to a light. It runs on a 102.4 kHz system clock. A free-running divider pulses a one-cycle enable once every 2^DIV_BITS clock cycles. With the default of ten bits, that enable arrives at 100 Hz, so each step of the count is ten milliseconds. A one-cycle start pulse sets an internal run flag. The flag lights the LED and allows a two-digit decimal counter to advance on each enable pulse. When the person presses the active-low button, the flag drops, the LED goes dark and the count freezes so it can be read.

The two digits are available both as raw decimal values and as seven-segment patterns. A synchronous active-low reset clears the digits, the flag and the divider phase. The button is expected to be clean and already synchronous to the clock.

Top module: `reaction_timer`

## Requirements
- R1: While the run flag is set, the count advances by exactly one on each divider pulse. A pulse occurs on the last cycle of every 2^DIV_BITS clock cycles, counted from the first cycle after reset.
- R2: The units digit counts 0 to 9 and returns to 0 after 9. The tens digit advances only on a step where the units digit is 9. Neither digit ever holds a value above 9.
- R3: Once the count shows 99, further steps while running leave it at 99 rather than wrapping.
- R4: A clock edge with `rst_n` low clears both digits, the run flag (LED off) and the divider phase.
- R5: A cycle with `start` high and `btn_n` high sets the run flag, and the LED is high from the following cycle onward.
- R6: A cycle with `btn_n` low clears the run flag even when `start` is high in the same cycle. Once the flag is clear, the count does not change.
- R7: Each seven-segment output is active-high, with segment a in bit 6 through segment g in bit 0. The patterns are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1111011.
- R8: A start pulse while the flag is already set has no effect on the count or on the divider phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (102.4 kHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a measurement |
| btn_n | input | 1 | Push-button, idles high, low when pressed |
| led | output | 1 | Lamp drive, high while timing |
| bcd_tens | output | 4 | Tens digit of elapsed time |
| bcd_units | output | 4 | Units digit of elapsed time |
| seg_tens | output | 7 | Segment pattern for the tens digit |
| seg_units | output | 7 | Segment pattern for the units digit |

## Verification
The bench uses a three-bit divider and sweeps the reaction delay over dozens of lengths. These lengths cross divider boundaries, units-to-tens carries and the ceiling at 99. The bench compares every output on every cycle against an arithmetic model.

A counter that wraps past 99 would show 00 after long runs. A missing carry gate would advance the tens digit on every step. A start that beat the button would leave the LED lit after a simultaneous press. A divider left running across reset would shift every step by some phase. Any of these shows up as a mismatched digit or LED value.

// File: rtl/rt_pkg.sv
// Shared definitions for the reaction timer: the digit type and the
// seven-segment encoding (active-high, segment a in bit 6, g in bit 0).
package rt_pkg;

    typedef logic [3:0] digit_t;
    typedef logic [6:0] seg_t;

    localparam digit_t DIGIT_MAX = 4'd9;

    // Map a decimal digit to its segment pattern; values above 9 blank.
    function automatic seg_t seg_encode(input digit_t d);
        seg_t s;
        case (d)
            4'd0: s = 7'b1111110;
            4'd1: s = 7'b0110000;
            4'd2: s = 7'b1101101;
            4'd3: s = 7'b1111001;
            4'd4: s = 7'b0110011;
            4'd5: s = 7'b1011011;
            4'd6: s = 7'b1011111;
            4'd7: s = 7'b1110000;
            4'd8: s = 7'b1111111;
            4'd9: s = 7'b1111011;
            default: s = 7'b0000000;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rt_tick_div.sv
// Free-running clock-enable divider. Emits a one-cycle pulse on the last
// cycle of every 2^DIV_BITS cycles. Assumes a synchronous active-low reset
// that restarts the phase at zero.
module rt_tick_div #(
    parameter int DIV_BITS = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [DIV_BITS-1:0] PHASE_LAST = {DIV_BITS{1'b1}};

    logic [DIV_BITS-1:0] phase_q;

    // Advance the phase counter each cycle, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == PHASE_LAST);

    generate
        if (DIV_BITS > 1) begin : g_pulse_chk
            assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rt_bcd_counter.sv
// Two-digit decimal counter. It steps once per cycle in which step_en is
// high. The units digit wraps 9->0, and the tens digit advances on the
// units carry. Holds at 99. Assumes step_en is a single-cycle enable.
module rt_bcd_counter
    import rt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_en,
    output digit_t tens,
    output digit_t units
);
    logic units_top;
    logic at_ceiling;

    assign units_top  = (units == DIGIT_MAX);
    assign at_ceiling = units_top && (tens == DIGIT_MAX);

    // Units digit: reload zero after nine, freeze at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                     units <= '0;
        else if (step_en && !at_ceiling) units <= units_top ? '0 : units + 4'd1;
    end

    // Tens digit: advance only when the units digit carries.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  tens <= '0;
        else if (step_en && !at_ceiling && units_top) tens <= tens + 4'd1;
    end

    assert_digit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (units <= DIGIT_MAX) && (tens <= DIGIT_MAX));

    assert_tens_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (tens != $past(tens))) |-> ($past(units) == DIGIT_MAX && units == 4'd0));

    assert_hold_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tens == DIGIT_MAX && units == DIGIT_MAX) |=> (tens == DIGIT_MAX && units == DIGIT_MAX));

endmodule

// File: rtl/rt_seg7.sv
// Combinational seven-segment decoder for one decimal digit.
// Assumes the digit is in 0..9. Larger values produce a blank pattern.
module rt_seg7
    import rt_pkg::*;
(
    input  digit_t digit,
    output seg_t   seg
);
    // Look up the pattern for the current digit.
    always_comb seg = seg_encode(digit);
endmodule

// File: rtl/reaction_timer.sv
// Reaction timer top. A start pulse sets the run flag, which lights the LED
// and gates the divider pulse into the decimal counter. A low button clears
// the flag and wins over start. Assumes btn_n is clean and synchronous.
module reaction_timer
    import rt_pkg::*;
#(
    parameter int DIV_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       btn_n,
    output logic       led,
    output logic [3:0] bcd_tens,
    output logic [3:0] bcd_units,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_units
);
    logic   tick;
    logic   run_q;
    digit_t tens_d;
    digit_t units_d;

    rt_tick_div #(.DIV_BITS(DIV_BITS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Run flag: the button clears it with priority, and start sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b0;
        else if (!btn_n) run_q <= 1'b0;
        else if (start)  run_q <= 1'b1;
    end

    rt_bcd_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (tick && run_q),
        .tens    (tens_d),
        .units   (units_d)
    );

    rt_seg7 u_seg_t (.digit(tens_d),  .seg(seg_tens));
    rt_seg7 u_seg_u (.digit(units_d), .seg(seg_units));

    assign led       = run_q;
    assign bcd_tens  = tens_d;
    assign bcd_units = units_d;

    assert_start_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && btn_n) |=> led);

    assert_btn_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_n |=> !led);

    assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !led |=> ($stable(bcd_tens) && $stable(bcd_units)));

endmodule

// File: tb/reaction_timer_bench.sv
// Bench for reaction_timer with a short divider. A cycle-level arithmetic
// model predicts every output, and each output is compared on every falling edge.
module reaction_timer_bench;
    localparam int DB = 3;
    localparam int D  = 1 << DB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       btn_n = 1'b1;
    logic       led;
    logic [3:0] bcd_tens, bcd_units;
    logic [6:0] seg_tens, seg_units;

    int n_cmp  = 0;
    int n_bad  = 0;
    int m_cyc  = 0;
    int m_cnt  = 0;
    bit m_run  = 0;
    int cycles = 0;
    string scen = "R4";

    reaction_timer #(.DIV_BITS(DB)) u_reaction_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .btn_n(btn_n), .led(led),
        .bcd_tens(bcd_tens), .bcd_units(bcd_units),
        .seg_tens(seg_tens), .seg_units(seg_units)
    );

    always #5 clk = ~clk;

    // Reference model, updated from the inputs seen at each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cyc = 0; m_run = 0; m_cnt = 0;
        end else begin
            if (m_run && (m_cyc % D) == D - 1 && m_cnt < 99) m_cnt++;
            if (!btn_n)     m_run = 0;
            else if (start) m_run = 1;
            m_cyc++;
        end
    end

    function automatic logic [6:0] exp_seg(input int d);
        case (d)
            0: return 7'b1111110;  1: return 7'b0110000;
            2: return 7'b1101101;  3: return 7'b1111001;
            4: return 7'b0110011;  5: return 7'b1011011;
            6: return 7'b1011111;  7: return 7'b1110000;
            8: return 7'b1111111;  9: return 7'b1111011;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One cycle: sample at the falling edge, then drive the next inputs.
    task automatic cyc(input logic st, input logic bn);
        @(negedge clk);
        cmp({scen, " led R5/R6"}, int'(led), int'(m_run));
        cmp({scen, " tens R2"},   int'(bcd_tens), m_cnt / 10);
        cmp({scen, " units R2"},  int'(bcd_units), m_cnt % 10);
        cmp({scen, " segT R7"},   int'(seg_tens), int'(exp_seg(m_cnt / 10)));
        cmp({scen, " segU R7"},   int'(seg_units), int'(exp_seg(m_cnt % 10)));
        start = st;
        btn_n = bn;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        wait (cycles > 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R4: reset state
        scen = "R4";
        do_reset();
        idle(3);
        cmp("R4 led after reset", int'(led), 0);
        cmp("R4 digits after reset", int'({bcd_tens, bcd_units}), 0);

        // R1/R2/R6: sweep reaction delays over divider phases and carries
        for (int len = 0; len < 860; len += 13) begin
            scen = (len > 800) ? "R3" : "R1";
            do_reset();
            idle(len % 5);
            cyc(1'b1, 1'b1);
            idle(len);
            cyc(1'b0, 1'b0);
            scen = "R6";
            idle(3 * D);
        end

        // R3: long run saturates at 99 and stays
        scen = "R3";
        do_reset();
        cyc(1'b1, 1'b1);
        idle(110 * D);
        cmp("R3 ceiling", int'({bcd_tens, bcd_units}), 8'h99);
        cyc(1'b0, 1'b0);
        idle(D);

        // R6: start and button together leave the flag clear
        scen = "R6";
        do_reset();
        cyc(1'b1, 1'b0);
        idle(4 * D);
        cmp("R6 simultaneous led", int'(led), 0);
        // button held low while start pulses: still idle
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        idle(2 * D);

        // R8: repeated start during a run changes nothing
        scen = "R8";
        do_reset();
        cyc(1'b1, 1'b1);
        for (int k = 0; k < 40; k++) begin
            cyc(1'b1, 1'b1);
            idle(k % 7);
        end
        cyc(1'b0, 1'b0);
        idle(D);

        // R4: reset in the middle of a run
        scen = "R4";
        do_reset();
        cyc(1'b1, 1'b1);
        idle(5 * D + 3);
        do_reset();
        idle(2 * D);
        cmp("R4 mid-run led", int'(led), 0);
        cmp("R4 mid-run digits", int'({bcd_tens, bcd_units}), 0);
        // restart after reset uses a fresh divider phase
        cyc(1'b1, 1'b1);
        idle(3 * D);
        cyc(1'b0, 1'b0);
        idle(D);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule